// File: doc/BRIEF.md
# Bit-Vector Coherence Directory Controller

This block is the home-side directory for a shared-memory coherence scheme. For every memory block it keeps a small entry: a home flag, a shared flag and a presence vector. When the home flag is set, no cache holds the block, and the other two fields mean nothing. When the home flag is clear and the shared flag is set, every cache whose presence bit is set holds a read-only copy. When both flags are clear, the one set presence bit names the cache that holds the only writable copy.

A requester presents a read or write for a block index, tagged with its cache ID. The controller looks up the entry and works out which caches must give up or hand back their copy. It sends a single multicast command to those caches and counts their acknowledgements. After the last one arrives it rewrites the entry and reports completion to the requester. Only one transaction is in progress at a time.

The request port is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold `req_valid` and the request fields steady. The command, acknowledgement and completion pins are plain one-cycle strobes with no back-pressure. A build parameter selects coarse mode. In that mode one presence bit stands for a pair of caches (caches 2g and 2g+1 share bit g).

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every block is in the home state, `req_ready` is 1, and `busy`, `cmd_valid` and `done_valid` are 0.
- R2: A read to a home block sends no command and grants with `done_excl`=0. The entry becomes shared, with only the requester's presence bit set.
- R3: A read to a shared block sends no command and grants with `done_excl`=0. It adds the requester's bit to the vector.
- R4: A read to a block held exclusively by another cache sends one downgrade command (`cmd_kind`=1) to the owner. After the ack the entry is shared, with both owner and requester marked. A read by the owner itself completes at once with `done_excl`=1 and leaves the entry unchanged.
- R5: A write to a shared block sends an invalidate (`cmd_kind`=0) to every marked cache except the requester. The entry becomes exclusive to the requester, and the grant has `done_excl`=1. If the requester is the only sharer, no command is sent.
- R6: A write to a block held exclusively by another cache sends a flush (`cmd_kind`=2) to the owner and then makes the requester the exclusive owner. A write by the current owner completes at once with no change.
- R7: A write to a home block sends no command. The entry becomes exclusive to the requester, and the grant has `done_excl`=1.
- R8: Completion waits until every cache named in `cmd_mask` has acknowledged. An ack from a cache that is not pending, or a repeated ack, has no effect.
- R9: While a transaction is open, `busy` is 1 and `req_ready` is 0. A request raised while the last ack arrives is taken only after `done_valid` has pulsed.
- R10: In coarse mode a presence bit covers caches 2g and 2g+1. A command goes to both members of each marked pair, except the requester. Each such cache must ack.
- R11: `cmd_valid` pulses for one cycle, in the cycle after the request is taken. `done_valid` pulses one cycle after the last counted ack, or one cycle after acceptance when no command is needed. `req_ready` returns in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request can be taken |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| req_id | input | $clog2(NCACHE) | Requesting cache ID |
| req_blk | input | $clog2(NBLK) | Block index |
| busy | output | 1 | A transaction is open |
| cmd_valid | output | 1 | Command strobe to caches |
| cmd_kind | output | 2 | 0 invalidate, 1 downgrade, 2 flush |
| cmd_mask | output | NCACHE | One bit per destination cache |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_id | input | $clog2(NCACHE) | Acknowledging cache ID |
| done_valid | output | 1 | Completion strobe |
| done_id | output | $clog2(NCACHE) | Requester being granted |
| done_excl | output | 1 | 1 when the requester now holds the block exclusively |

## Verification
Two events can fall in the same cycle: the final acknowledgement that closes a transaction, and a new request waiting at the port. The bench provokes this by raising the next request in the same cycle as the last ack. It then requires that `req_ready` is still low when `done_valid` pulses, and that the held request is taken only afterwards, with the entry already updated. It also sends stray and repeated acks while a transaction is open, and requires that completion does not come early. Both the one-bit-per-cache build and the paired build are run with random request mixes.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    CMD_INV   = 2'd0,
    CMD_DOWN  = 2'd1,
    CMD_FLUSH = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NBLK = 16,
  parameter int PW   = 8,
  localparam int BW  = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] rd_blk,
  output logic          rd_home,
  output logic          rd_shared,
  output logic [PW-1:0] rd_vec,
  input  logic          we,
  input  logic [BW-1:0] wr_blk,
  input  logic          wr_home,
  input  logic          wr_shared,
  input  logic [PW-1:0] wr_vec
);
  logic [NBLK-1:0] home_q;
  logic [NBLK-1:0] shared_q;
  logic [PW-1:0]   vec_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home_q   <= '1;
      shared_q <= '0;
      for (int i = 0; i < NBLK; i++) vec_q[i] <= '0;
    end else if (we) begin
      home_q[wr_blk]   <= wr_home;
      shared_q[wr_blk] <= wr_shared;
      vec_q[wr_blk]    <= wr_vec;
    end
  end

  assign rd_home   = home_q[rd_blk];
  assign rd_shared = shared_q[rd_blk];
  assign rd_vec    = vec_q[rd_blk];

  // an exclusive entry names exactly one presence bit
  assert_excl_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_home && !wr_shared) |-> ($countones(wr_vec) == 1));

  // a shared entry always marks at least one holder
  assert_shared_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wr_home && wr_shared) |-> (wr_vec != '0));
endmodule

// File: rtl/dir_next.sv
module dir_next
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 8,
  parameter int PW     = 8,
  parameter bit COARSE = 1'b0,
  localparam int IDW   = $clog2(NCACHE),
  localparam int GS    = COARSE ? 1 : 0
) (
  input  logic              is_write,
  input  logic [IDW-1:0]    id,
  input  logic              home,
  input  logic              shared,
  input  logic [PW-1:0]     vec,
  output logic [NCACHE-1:0] tgt,
  output cmd_kind_e         kind,
  output logic              n_home,
  output logic              n_shared,
  output logic [PW-1:0]     n_vec,
  output logic              excl_grant
);
  logic [NCACHE-1:0] expanded;
  logic [NCACHE-1:0] others;
  logic [PW-1:0]     reqbit;

  for (genvar p = 0; p < NCACHE; p++) begin : g_expand
    assign expanded[p] = vec[p >> GS];
  end

  assign reqbit = PW'(1) << (id >> GS);
  assign others = expanded & ~(NCACHE'(1) << id);

  always_comb begin
    tgt        = '0;
    kind       = CMD_INV;
    n_home     = home;
    n_shared   = shared;
    n_vec      = vec;
    excl_grant = 1'b0;
    if (home) begin
      n_home     = 1'b0;
      n_shared   = !is_write;
      n_vec      = reqbit;
      excl_grant = is_write;
    end else if (shared) begin
      if (is_write) begin
        tgt        = others;
        kind       = CMD_INV;
        n_shared   = 1'b0;
        n_vec      = reqbit;
        excl_grant = 1'b1;
      end else begin
        n_vec = vec | reqbit;
      end
    end else if (others == '0) begin
      excl_grant = 1'b1;
    end else if (is_write) begin
      tgt        = others;
      kind       = CMD_FLUSH;
      n_vec      = reqbit;
      excl_grant = 1'b1;
    end else begin
      tgt      = others;
      kind     = CMD_DOWN;
      n_shared = 1'b1;
      n_vec    = vec | reqbit;
    end
  end
endmodule

// File: rtl/ack_tracker.sv
module ack_tracker #(
  parameter int NCACHE = 8,
  localparam int IDW   = $clog2(NCACHE),
  localparam int CW    = $clog2(NCACHE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCACHE-1:0] load_mask,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_id,
  output logic [CW-1:0]     cnt,
  output logic              last
);
  logic [NCACHE-1:0] pend_q;
  logic [CW-1:0]     cnt_q;
  logic              hit;

  function automatic logic [CW-1:0] popc(input logic [NCACHE-1:0] m);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NCACHE; i++) s = s + CW'(m[i]);
    return s;
  endfunction

  assign hit  = ack_valid && pend_q[ack_id];
  assign last = hit && (cnt_q == CW'(1));
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      pend_q <= load_mask;
      cnt_q  <= popc(load_mask);
    end else if (hit) begin
      pend_q[ack_id] <= 1'b0;
      cnt_q          <= cnt_q - CW'(1);
    end
  end

  // the count always equals the caches still owing an ack
  assert_cnt_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(pend_q)));

  // a new fan-out is never loaded over an unfinished one
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NCACHE = 8,
  parameter int NBLK   = 16,
  parameter bit COARSE = 1'b0,
  localparam int IDW   = $clog2(NCACHE),
  localparam int BW    = $clog2(NBLK),
  localparam int PW    = COARSE ? NCACHE / 2 : NCACHE,
  localparam int CW    = $clog2(NCACHE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDW-1:0]    req_id,
  input  logic [BW-1:0]     req_blk,
  output logic              busy,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [NCACHE-1:0] cmd_mask,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_id,
  output logic              done_valid,
  output logic [IDW-1:0]    done_id,
  output logic              done_excl
);
  ctl_state_e        state_q;
  logic              accept;
  logic              e_home, e_shared;
  logic [PW-1:0]     e_vec;
  logic [NCACHE-1:0] nx_tgt;
  cmd_kind_e         nx_kind;
  logic              nx_home, nx_shared, nx_grant;
  logic [PW-1:0]     nx_vec;

  logic [IDW-1:0]    cur_id;
  logic [BW-1:0]     cur_blk;
  logic [NCACHE-1:0] tgt_q;
  cmd_kind_e         kind_q;
  logic              grant_q, nh_q, ns_q;
  logic [PW-1:0]     nv_q;
  logic [CW-1:0]     trk_cnt;
  logic              trk_last;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  dir_store #(.NBLK(NBLK), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_home(e_home), .rd_shared(e_shared), .rd_vec(e_vec),
    .we(state_q == ST_DONE), .wr_blk(cur_blk),
    .wr_home(nh_q), .wr_shared(ns_q), .wr_vec(nv_q)
  );

  dir_next #(.NCACHE(NCACHE), .PW(PW), .COARSE(COARSE)) u_next (
    .is_write(req_write), .id(req_id),
    .home(e_home), .shared(e_shared), .vec(e_vec),
    .tgt(nx_tgt), .kind(nx_kind),
    .n_home(nx_home), .n_shared(nx_shared), .n_vec(nx_vec),
    .excl_grant(nx_grant)
  );

  ack_tracker #(.NCACHE(NCACHE)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (nx_tgt != '0)), .load_mask(nx_tgt),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .cnt(trk_cnt), .last(trk_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_id  <= '0;
      cur_blk <= '0;
      tgt_q   <= '0;
      kind_q  <= CMD_INV;
      grant_q <= 1'b0;
      nh_q    <= 1'b1;
      ns_q    <= 1'b0;
      nv_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cur_id  <= req_id;
          cur_blk <= req_blk;
          tgt_q   <= nx_tgt;
          kind_q  <= nx_kind;
          grant_q <= nx_grant;
          nh_q    <= nx_home;
          ns_q    <= nx_shared;
          nv_q    <= nx_vec;
          state_q <= (nx_tgt != '0) ? ST_CMD : ST_DONE;
        end
        ST_CMD:  state_q <= trk_last ? ST_DONE : ST_WAIT;
        ST_WAIT: if (trk_last) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (state_q == ST_CMD);
  assign cmd_kind   = kind_q;
  assign cmd_mask   = tgt_q;
  assign done_valid = (state_q == ST_DONE);
  assign done_id    = cur_id;
  assign done_excl  = grant_q;

  assert_cmd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_done_to_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> (req_ready && !done_valid));

  assert_not_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_mask[cur_id]);

  assert_cmd_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_mask != '0));

  assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_done_acks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (trk_cnt == '0));
endmodule

// File: tb/sim_coh_dir_ctrl.sv
module bench_core #(
  parameter bit COARSE = 1'b0
) (
  input  logic clk,
  output logic fin,
  output int   checks,
  output int   errs
);
  localparam int NC  = 8;
  localparam int NB  = 16;
  localparam int PW  = COARSE ? NC / 2 : NC;
  localparam int GS  = COARSE ? 1 : 0;

  logic          rst_n;
  logic          req_valid, req_ready, req_write, busy;
  logic [2:0]    req_id, ack_id, done_id;
  logic [3:0]    req_blk;
  logic          cmd_valid, ack_valid, done_valid, done_excl;
  logic [1:0]    cmd_kind;
  logic [NC-1:0] cmd_mask;

  coh_dir_ctrl #(.NCACHE(NC), .NBLK(NB), .COARSE(COARSE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_id(req_id), .req_blk(req_blk), .busy(busy),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask),
    .ack_valid(ack_valid), .ack_id(ack_id),
    .done_valid(done_valid), .done_id(done_id), .done_excl(done_excl)
  );

  bit            mh [NB];
  bit            ms [NB];
  logic [PW-1:0] mv [NB];

  logic [NC-1:0] e_tgt;
  int            e_kind;
  bit            e_nh, e_ns, e_excl;
  logic [PW-1:0] e_nv;
  string         e_req;
  bit            nx_w;
  int            nx_id, nx_blk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (coarse=%0d) actual=%0d expected=%0d", rq, COARSE, act, exp);
    end
  endtask

  // expected outcome from the requirement text
  task automatic calc(input bit w, input int id, input int blk);
    logic [NC-1:0] oth;
    logic [PW-1:0] rb;
    rb = PW'(1) << (id >> GS);
    oth = '0;
    for (int p = 0; p < NC; p++) if (mv[blk][p >> GS] && p != id) oth[p] = 1'b1;
    e_tgt = '0; e_kind = 0; e_nh = mh[blk]; e_ns = ms[blk]; e_nv = mv[blk]; e_excl = 0;
    if (mh[blk]) begin
      e_req = w ? "R7" : "R2";
      e_nh = 0; e_ns = !w; e_nv = rb; e_excl = w;
    end else if (ms[blk]) begin
      e_req = w ? "R5" : "R3";
      if (w) begin e_tgt = oth; e_kind = 0; e_ns = 0; e_nv = rb; e_excl = 1; end
      else e_nv = mv[blk] | rb;
    end else begin
      e_req = w ? "R6" : "R4";
      if (oth == '0) e_excl = 1;
      else if (w) begin e_tgt = oth; e_kind = 2; e_nv = rb; e_excl = 1; end
      else begin e_tgt = oth; e_kind = 1; e_ns = 1; e_nv = mv[blk] | rb; end
    end
    if (COARSE && e_tgt != '0) e_req = "R10";
  endtask

  // mode 0 plain, 1 stray and repeated acks, 2 next request raised with last ack
  task automatic do_req(input bit w, input int id, input int blk, input int mode);
    int left;
    bit first;
    calc(w, id, blk);
    @(negedge clk);
    req_valid = 1; req_write = w; req_id = 3'(id); req_blk = 4'(blk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (e_tgt != '0) begin
      chk(cmd_valid === 1'b1, "R11", int'(cmd_valid), 1);
      chk(cmd_mask === e_tgt, e_req, int'(cmd_mask), int'(e_tgt));
      chk(int'(cmd_kind) == e_kind, e_req, int'(cmd_kind), e_kind);
      chk(busy === 1'b1 && req_ready === 1'b0, "R9", int'(req_ready), 0);
      if (mode == 1) begin
        ack_valid = 1; ack_id = 3'(id);
        @(negedge clk);
        chk(done_valid === 1'b0, "R8", int'(done_valid), 0);
      end
      left = $countones(e_tgt);
      first = 1;
      for (int p = 0; p < NC; p++) begin
        if (e_tgt[p]) begin
          ack_valid = 1; ack_id = 3'(p);
          left--;
          if (left == 0 && mode == 2) begin
            req_valid = 1; req_write = nx_w; req_id = 3'(nx_id); req_blk = 4'(nx_blk);
          end
          @(negedge clk);
          if (left != 0) begin
            chk(done_valid === 1'b0, "R8", int'(done_valid), 0);
            if (mode == 1 && first) begin
              ack_id = 3'(p);
              @(negedge clk);
              chk(done_valid === 1'b0, "R8", int'(done_valid), 0);
            end
            ack_valid = 0;
            repeat ($urandom % 3) begin
              @(negedge clk);
              chk(done_valid === 1'b0, "R8", int'(done_valid), 0);
            end
          end
          first = 0;
        end
      end
      ack_valid = 0;
    end else begin
      chk(cmd_valid === 1'b0, e_req, int'(cmd_valid), 0);
    end
    chk(done_valid === 1'b1, "R11", int'(done_valid), 1);
    chk(int'(done_id) == id, e_req, int'(done_id), id);
    chk(done_excl === e_excl, e_req, int'(done_excl), int'(e_excl));
    if (mode == 2 && e_tgt != '0)
      chk(req_ready === 1'b0 && cmd_valid === 1'b0, "R9", int'(req_ready), 0);
    mh[blk] = e_nh; ms[blk] = e_ns; mv[blk] = e_nv;
  endtask

  initial begin
    bit cw;
    int cid, cblk, cmode;
    fin = 0; checks = 0; errs = 0;
    void'($urandom(COARSE ? 32'd91 : 32'd17));
    rst_n = 0; req_valid = 0; req_write = 0; req_id = 0; req_blk = 0;
    ack_valid = 0; ack_id = 0;
    for (int b = 0; b < NB; b++) begin mh[b] = 1; ms[b] = 0; mv[b] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R1", int'(req_ready), 1);
    chk(cmd_valid === 1'b0 && done_valid === 1'b0, "R1", int'(cmd_valid), 0);
    // directed corner cases
    do_req(0, 1, 0, 0);   // home read
    do_req(0, 3, 0, 0);   // shared read
    do_req(1, 5, 0, 1);   // write to shared with stray and repeated acks
    do_req(0, 2, 0, 0);   // read of a block another cache owns
    do_req(1, 2, 0, 0);   // write from one sharer
    do_req(1, 2, 0, 0);   // write by the owner
    do_req(0, 2, 0, 0);   // read by the owner
    nx_w = 0; nx_id = 0; nx_blk = 1;
    do_req(1, 6, 0, 2);   // last ack coincides with the next request
    do_req(0, 0, 1, 0);
    do_req(1, 4, 3, 0);   // home write
    do_req(1, 4, 3, 0);
    for (int b = 4; b < NB; b++) do_req(0, b % NC, b, 0);   // untouched blocks start home
    // random mix
    nx_w = 1'($urandom); nx_id = $urandom % NC; nx_blk = $urandom % 4;
    for (int i = 0; i < 300; i++) begin
      cw = nx_w; cid = nx_id; cblk = nx_blk; cmode = $urandom % 3;
      nx_w = 1'($urandom); nx_id = $urandom % NC; nx_blk = $urandom % 4;
      do_req(cw, cid, cblk, cmode);
    end
    @(negedge clk);
    chk(req_ready === 1'b1 && busy === 1'b0, "R11", int'(req_ready), 1);
    fin = 1;
  end
endmodule

module sim_coh_dir_ctrl;
  logic clk = 0;
  logic fin_a, fin_b;
  int   ck_a, ck_b, er_a, er_b;
  int   wd_err;

  always #4 clk = ~clk;

  bench_core #(.COARSE(1'b0)) u_fine   (.clk(clk), .fin(fin_a), .checks(ck_a), .errs(er_a));
  bench_core #(.COARSE(1'b1)) u_coarse (.clk(clk), .fin(fin_b), .checks(ck_b), .errs(er_b));

  initial begin
    wd_err = 0;
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (fin_a === 1'b1 && fin_b === 1'b1) break;
    end
    if (!(fin_a === 1'b1 && fin_b === 1'b1)) begin
      wd_err = 1;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("  CHECKS %0d ERRORS %0d", ck_a + ck_b + wd_err, er_a + er_b + wd_err);
    $finish;
  end
endmodule